// File: doc/BRIEF.md
# Bidirectional Byte Buffer with Word Packing

This block is a 32-entry, 8-bit-wide buffer placed between a 32-bit host or DMA bus and a card engine that moves one byte at a time. A single storage array carries traffic in both directions, and a direction input chooses the mode. In receive mode the card side writes bytes and the host reads 32-bit words. In transmit mode the host writes 32-bit words and the card side reads bytes. Word lanes map to bytes little-endian.

The buffer watches its fill level against a selectable byte threshold. When enough data is held (receive) or enough space is free (transmit), it raises a one-cycle DMA request pulse and sets a sticky interrupt flag. It also drives full and empty flags.

All four data paths use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The block may hold ready or valid low at any time to stall its partner. A host that drives valid on the write path, or ready on the read path, while the block side is low does not move data. That attempt is recorded in a sticky error flag, and the host may keep the request up and it completes later.

Top module: `byte_fifo_pack`

## Requirements
- R1: A host word maps to bytes little-endian. Bits 7:0 are the first byte into or out of the buffer and bits 31:24 are the last.
- R2: With `dir_tx`=0 (receive), the card side writes and the host side reads. With `dir_tx`=1 (transmit), the host side writes and the card side reads. Data leaves in the order it entered. On every clock `level` changes by the bytes written minus the bytes read, and the card side moves at most one byte per clock.
- R3: `empty` is high exactly when `level`=0, and `full` is high exactly when `level`=32. While full, `cb_in_ready` is low and a card byte offered then is ignored, leaving `level` unchanged.
- R4: `hw_ready` is high only in transmit mode with at least 4 bytes free. `hr_valid` is high only in receive mode with at least 4 bytes held.
- R5: `ovr` becomes set when, in transmit mode, `hw_valid` is high while `hw_ready` is low. `udr` becomes set when, in receive mode, `hr_ready` is high while `hr_valid` is low. Both flags stay set until a flush or a change of direction, and an attempt that sets them moves no data.
- R6: The threshold is 16 bytes when `thr_sel`=0 and 32 bytes when `thr_sel`=1. The request condition is occupancy ≥ threshold in receive mode and free space ≥ threshold in transmit mode.
- R7: `dma_evt` is high for one cycle when the condition holds and the request is armed. It then re-arms only after the host has moved a threshold's worth of bytes following that pulse. A flush also re-arms it.
- R8: `irq` is set in the cycle after `dma_evt` and stays set until `irq_clr` is seen. If `irq_clr` and `dma_evt` fall in the same cycle, `irq` ends set.
- R9: A high `flush`, or a change of `dir_tx`, empties the buffer and clears `ovr` and `udr` at the next edge. During that cycle all four ready/valid outputs are low.
- R10: After reset the buffer is empty, in receive mode, with all flags and `irq` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the buffer at the next edge |
| dir_tx | input | 1 | 0 receive, 1 transmit |
| thr_sel | input | 1 | Threshold select: 0 gives 16 bytes, 1 gives 32 |
| irq_clr | input | 1 | Clear the interrupt flag |
| hw_valid | input | 1 | Host write word valid |
| hw_ready | output | 1 | Host write word accepted |
| hw_data | input | 32 | Host write word |
| hr_valid | output | 1 | Host read word available |
| hr_ready | input | 1 | Host takes the read word |
| hr_data | output | 32 | Host read word |
| cb_in_valid | input | 1 | Card byte offered |
| cb_in_ready | output | 1 | Card byte accepted |
| cb_in_data | input | 8 | Card byte in |
| cb_out_valid | output | 1 | Byte available to card |
| cb_out_ready | input | 1 | Card takes the byte |
| cb_out_data | output | 8 | Byte to card |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| level | output | 6 | Bytes held |
| ovr | output | 1 | Sticky write overrun |
| udr | output | 1 | Sticky read underrun |
| dma_evt | output | 1 | One-cycle DMA request |
| irq | output | 1 | Sticky interrupt |

## Verification
A request pulse and a software interrupt clear can fall in the same cycle. Both try to drive the interrupt flag, in opposite directions. The bench provokes this case in receive mode. It drains exactly one threshold of words, so the request re-arms with occupancy still at the threshold. It then raises `irq_clr` in the cycle where the pulse is expected. The check is that `irq` reads set afterwards and that exactly one more pulse was counted.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  typedef enum logic {MODE_RX = 1'b0, MODE_TX = 1'b1} mode_e;

  // Threshold in bytes: half the buffer or the whole buffer
  function automatic int unsigned thr_bytes(input logic sel, input int unsigned depth);
    return sel ? depth : depth / 2;
  endfunction
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store #(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push1,
  input  logic                    push_word,
  input  logic [BYTE_W-1:0]       pin_byte,
  input  logic [LANES*BYTE_W-1:0] pin_word,
  input  logic                    pop1,
  input  logic                    pop_word,
  output logic [BYTE_W-1:0]       rd_byte,
  output logic [LANES*BYTE_W-1:0] rd_word,
  output logic [LW-1:0]           level
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [LW-1:0]     n_in, n_out;

  assign n_in  = push1 ? LW'(1) : (push_word ? LW'(LANES) : '0);
  assign n_out = pop1  ? LW'(1) : (pop_word  ? LW'(LANES) : '0);

  always_ff @(posedge clk) begin
    if (push1) begin
      mem[wr_ptr] <= pin_byte;
    end else if (push_word) begin
      for (int l = 0; l < LANES; l++)
        mem[wr_ptr + AW'(l)] <= pin_word[l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(n_in);
      rd_ptr <= rd_ptr + AW'(n_out);
      level  <= level + n_in - n_out;
    end
  end

  assign rd_byte = mem[rd_ptr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*BYTE_W +: BYTE_W] = mem[rd_ptr + AW'(g)];
  end
endmodule

// File: rtl/byte_fifo_event.sv
module byte_fifo_event #(
  parameter int LW    = 6,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cond,
  input  logic          host_mv,
  input  logic [LW-1:0] thr,
  input  logic          irq_clr,
  output logic          dma_evt,
  output logic          irq
);
  logic          armed;
  logic [LW:0]   moved;
  logic [LW:0]   moved_nx;

  assign dma_evt  = armed && cond;
  assign moved_nx = moved + (LW+1)'(LANES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      moved <= '0;
    end else if (clr) begin
      armed <= 1'b1;
      moved <= '0;
    end else if (dma_evt) begin
      armed <= 1'b0;
      moved <= '0;
    end else if (!armed && host_mv) begin
      if (moved_nx >= {1'b0, thr}) begin
        armed <= 1'b1;
        moved <= '0;
      end else begin
        moved <= moved_nx;
      end
    end
  end

  // A new request outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (dma_evt) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end
endmodule

// File: rtl/byte_fifo_pack.sv
module byte_fifo_pack
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / BYTE_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              dir_tx,
  input  logic              thr_sel,
  input  logic              irq_clr,
  input  logic              hw_valid,
  output logic              hw_ready,
  input  logic [WORD_W-1:0] hw_data,
  output logic              hr_valid,
  input  logic              hr_ready,
  output logic [WORD_W-1:0] hr_data,
  input  logic              cb_in_valid,
  output logic              cb_in_ready,
  input  logic [BYTE_W-1:0] cb_in_data,
  output logic              cb_out_valid,
  input  logic              cb_out_ready,
  output logic [BYTE_W-1:0] cb_out_data,
  output logic              full,
  output logic              empty,
  output logic [LW-1:0]     level,
  output logic              ovr,
  output logic              udr,
  output logic              dma_evt,
  output logic              irq
);
  mode_e         mode, mode_q;
  logic          mode_chg, clr, live, rx;
  logic          push1, pop1, push_word, pop_word;
  logic [LW-1:0] thr, free_b;
  logic          cond;

  assign mode     = mode_e'(dir_tx);
  assign mode_chg = (mode != mode_q);
  assign clr      = flush || mode_chg;
  assign live     = !clr;
  assign rx       = (mode == MODE_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RX;
    else        mode_q <= mode;
  end

  assign free_b       = LW'(DEPTH) - level;
  assign cb_in_ready  = live && rx  && (level < LW'(DEPTH));
  assign hr_valid     = live && rx  && (level >= LW'(LANES));
  assign hw_ready     = live && !rx && (free_b >= LW'(LANES));
  assign cb_out_valid = live && !rx && (level != '0);

  assign push1     = cb_in_valid  && cb_in_ready;
  assign pop_word  = hr_valid     && hr_ready;
  assign push_word = hw_valid     && hw_ready;
  assign pop1      = cb_out_valid && cb_out_ready;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  byte_fifo_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .LANES(LANES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push1     (push1),
    .push_word (push_word),
    .pin_byte  (cb_in_data),
    .pin_word  (hw_data),
    .pop1      (pop1),
    .pop_word  (pop_word),
    .rd_byte   (cb_out_data),
    .rd_word   (hr_data),
    .level     (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0;
      udr <= 1'b0;
    end else if (clr) begin
      ovr <= 1'b0;
      udr <= 1'b0;
    end else begin
      if (!rx && hw_valid && !hw_ready) ovr <= 1'b1;
      if (rx && hr_ready && !hr_valid)  udr <= 1'b1;
    end
  end

  assign thr  = LW'(thr_bytes(thr_sel, DEPTH));
  assign cond = live && (rx ? (level >= thr) : (free_b >= thr));

  byte_fifo_event #(.LW(LW), .LANES(LANES)) u_event (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cond    (cond),
    .host_mv (push_word || pop_word),
    .thr     (thr),
    .irq_clr (irq_clr),
    .dma_evt (dma_evt),
    .irq     (irq)
  );
endmodule

// File: rtl/byte_fifo_pack_chk.sv
module byte_fifo_pack_chk #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          dir_tx,
  input logic          irq_clr,
  input logic          hw_ready,
  input logic          hr_valid,
  input logic          cb_in_ready,
  input logic          full,
  input logic          empty,
  input logic [LW-1:0] level,
  input logic          ovr,
  input logic          dma_evt,
  input logic          irq
);
  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !cb_in_ready);
  assert_wr_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ready |-> (level <= LW'(DEPTH - LANES)) && dir_tx);
  assert_rd_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hr_valid |-> (level >= LW'(LANES)) && !dir_tx);
  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !flush && $stable(dir_tx)) |=> ovr);
  assert_evt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt |=> !dma_evt);
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt |=> irq);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !dma_evt) |=> !irq);
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

bind byte_fifo_pack byte_fifo_pack_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (.*);

// File: tb/byte_fifo_pack_tb.sv
module byte_fifo_pack_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 0, dir_tx = 0, thr_sel = 0, irq_clr = 0;
  logic        hw_valid = 0, hr_ready = 0, cb_in_valid = 0, cb_out_ready = 0;
  logic [31:0] hw_data = '0;
  logic [7:0]  cb_in_data = '0;
  logic        hw_ready, hr_valid, cb_in_ready, cb_out_valid;
  logic [31:0] hr_data;
  logic [7:0]  cb_out_data;
  logic        full, empty, ovr, udr, dma_evt, irq;
  logic [5:0]  level;

  int n_chk = 0, n_fail = 0, evt_cnt = 0;

  // op 0: host writes word; op 1: card pops byte (data[7:0] expected); last field = level after
  localparam logic [43:0] TV [8] = '{
    {4'd0, 32'h44332211, 8'd4},
    {4'd1, 32'h00000011, 8'd3},
    {4'd1, 32'h00000022, 8'd2},
    {4'd0, 32'h88776655, 8'd6},
    {4'd1, 32'h00000033, 8'd5},
    {4'd1, 32'h00000044, 8'd4},
    {4'd1, 32'h00000055, 8'd3},
    {4'd1, 32'h00000066, 8'd2}
  };

  always #(CLK_P/2) clk = ~clk;

  byte_fifo_pack u_dut (.*);

  // count request pulses just before each rising edge
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n && dma_evt) evt_cnt++;
  end

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    cb_in_valid = 1; cb_in_data = b; tick(); cb_in_valid = 0;
  endtask

  task automatic write_word(input logic [31:0] w);
    hw_valid = 1; hw_data = w; tick(); hw_valid = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10 reset state
    chk("R10", "level", level, 0);
    chk("R10", "empty", empty, 1);
    chk("R10", "full", full, 0);
    chk("R10", "flags", {ovr, udr, irq, dma_evt}, 0);

    // R2/R1 receive: four card bytes become one little-endian word
    for (int i = 0; i < 4; i++) push_byte(8'hA1 + 8'(i));
    chk("R2", "rx level", level, 4);
    chk("R4", "hr_valid", hr_valid, 1);
    chk("R1", "rx word", hr_data, 32'hA4A3A2A1);
    hr_ready = 1; tick(); hr_ready = 0;
    chk("R3", "empty after read", empty, 1);

    // R5 underrun: read with fewer than 4 bytes held
    hr_ready = 1; tick(); hr_ready = 0;
    chk("R5", "udr", udr, 1);
    chk("R5", "level after underrun", level, 0);

    // R6/R7 threshold 16 in receive
    for (int i = 0; i < 16; i++) push_byte(8'(i));
    tick(); tick();
    chk("R7", "one pulse at 16", evt_cnt, 1);
    chk("R8", "irq set", irq, 1);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R8", "irq cleared", irq, 0);

    // R3 fill to full, extra byte ignored
    for (int i = 16; i < 32; i++) push_byte(8'(i));
    chk("R3", "full", full, 1);
    chk("R3", "cb_in_ready", cb_in_ready, 0);
    chk("R7", "no rearm without host", evt_cnt, 1);
    push_byte(8'hEE);
    chk("R3", "level held", level, 32);

    // drain one threshold; R8 clear and pulse in same cycle
    for (int i = 0; i < 4; i++) begin
      chk("R1", "rx word order", hr_data,
          {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
      hr_ready = 1; tick();
    end
    hr_ready = 0; irq_clr = 1; tick(); irq_clr = 0;
    chk("R8", "set wins over clear", irq, 1);
    chk("R7", "rearm after 16 moved", evt_cnt, 2);

    // R9 direction change flushes
    dir_tx = 1; tick();
    chk("R9", "level after dir change", level, 0);
    chk("R9", "udr cleared", udr, 0);
    tick();
    chk("R6", "tx free >= 16", evt_cnt, 3);
    irq_clr = 1; tick(); irq_clr = 0;

    // table walk in transmit
    for (int i = 0; i < 8; i++) begin
      if (TV[i][43:40] == 4'd0) begin
        write_word(TV[i][39:8]);
      end else begin
        chk("R1", "tx byte", cb_out_data, TV[i][15:8]);
        cb_out_ready = 1; tick(); cb_out_ready = 0;
      end
      chk("R2", "tx level", level, TV[i][7:0]);
    end

    // R4/R5 transmit space limit and overrun
    for (int i = 0; i < 7; i++) write_word(32'h1000 + 32'(i));
    chk("R4", "hw_ready low at 30", hw_ready, 0);
    chk("R7", "rearm in tx", evt_cnt, 4);
    write_word(32'hDEADBEEF);
    chk("R5", "ovr", ovr, 1);
    chk("R5", "level unchanged", level, 30);
    chk("R2", "fifo order", cb_out_data, 8'h77);

    // R9 flush, R6 threshold 32
    thr_sel = 1; flush = 1; tick(); flush = 0;
    chk("R9", "flush level", level, 0);
    chk("R9", "ovr cleared", ovr, 0);
    tick();
    chk("R6", "tx free >= 32", evt_cnt, 5);
    write_word(32'h01020304);
    tick(); tick();
    chk("R6", "no pulse below 32 free", evt_cnt, 5);

    finish_run();
  end
endmodule